// File: doc/BRIEF.md
# Single-Clock FIFO with Reset-Programmed Half-Full Threshold

This block is a first-in first-out buffer for 9-bit words with one clock. The write strobe, the read strobe and the reset are all active low and are sampled on the rising clock edge. Three status outputs, also active low, report that the buffer is empty, that it is full, and that its fill level has reached a programmable threshold.

The threshold register has no configuration port. It is loaded only while reset is held low. A write strobe during reset copies the data input into the threshold register. A read strobe during reset copies the current value of the output data register into it. If neither strobe is given, the register keeps its previous value. Until the block has seen its first reset, every write and read is refused. The buffer depth is a parameter, and the word count is derived from two wrapping pointers that each carry one extra lap bit.

Top module: `fifo9_pflag`

## Requirements
- R1: A clock edge with `rst_n` low returns both pointers to the first entry. After reset the buffer reads as empty, and the first word read back is the first word written after the reset.
- R2: Before the first reset, write and read strobes have no effect and `empty_n` stays low.
- R3: A clock edge with `rst_n` low and `wr_n` low loads the threshold register from `din`. The write strobe takes priority over the read strobe.
- R4: A clock edge with `rst_n` low, `rd_n` low and `wr_n` high loads the threshold register from the current `dout`. `dout` itself does not change during reset.
- R5: A reset edge with both strobes high leaves the threshold register unchanged.
- R6: While `rst_n` is low (after the first reset edge), `empty_n` is 0, `full_n` is 1 and `half_n` is 1.
- R7: Outside reset, `half_n` is 0 exactly when the stored word count is greater than or equal to the threshold value. A threshold of 0 therefore makes `half_n` 0 even when the buffer is empty.
- R8: Words come out in the order they were written. An accepted read updates `dout` at the clock edge that accepts it, and `dout` holds its value in every cycle without an accepted read.
- R9: `full_n` is 0 when DEPTH words are stored. A write while full is dropped without disturbing the stored data. A simultaneous read while full is still accepted.
- R10: A read while empty is ignored, and `dout` keeps its value. A simultaneous write while empty is still accepted.
- R11: A simultaneous read and write while neither empty nor full keeps the word count unchanged and advances both pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low, sampled on the clock |
| wr_n | input | 1 | Write strobe, active low; during reset it loads the threshold from `din` |
| rd_n | input | 1 | Read strobe, active low; during reset it loads the threshold from `dout` |
| din | input | 9 | Write data and threshold source |
| dout | output | 9 | Registered read data |
| empty_n | output | 1 | Buffer empty, active low |
| full_n | output | 1 | Buffer full, active low |
| half_n | output | 1 | Fill level at or above the threshold, active low |

## Verification
Every result of this block is due on the first rising edge after a stimulus. The read word lands in `dout`, and the pointers and threshold register update, on that edge. The three flags are decoded combinationally from the pointers, from the threshold and from `rst_n`, so they also settle within that cycle. The bench changes its inputs on the falling edge, lets exactly one rising edge pass, and compares at the next falling edge. That way each vector's expectation describes the state one edge after the vector was applied. The reset-phase flag checks are made at that same falling edge while `rst_n` is still low, before the release is driven.

// File: rtl/fifo9_pflag_pkg.sv
package fifo9_pflag_pkg;

   // Source selected for the threshold register on a reset edge
   typedef enum logic [1:0] {
      TL_KEEP     = 2'd0,
      TL_FROM_IN  = 2'd1,
      TL_FROM_OUT = 2'd2
   } tload_e;

   // Port-level status, all active low
   typedef struct packed {
      logic empty_n;
      logic full_n;
      logic half_n;
   } flags_t;

   function automatic tload_e pick_tload(input logic rst_n, input logic wr_n,
                                         input logic rd_n);
      if (rst_n)      return TL_KEEP;
      else if (!wr_n) return TL_FROM_IN;
      else if (!rd_n) return TL_FROM_OUT;
      else            return TL_KEEP;
   endfunction

endpackage

// File: rtl/fifo9_ptr.sv
module fifo9_ptr #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          adv,
   output logic [AW:0]   ptr
);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [AW:0] ptr_q;

   generate
      if (POW2) begin : g_pow2
         // index and lap bit wrap together
         always_ff @(posedge clk) begin
            if (clr)      ptr_q <= '0;
            else if (adv) ptr_q <= ptr_q + 1'b1;
         end
      end else begin : g_wrap
         // explicit wrap of the index at DEPTH-1, toggling the lap bit
         always_ff @(posedge clk) begin
            if (clr) begin
               ptr_q <= '0;
            end else if (adv) begin
               if (ptr_q[AW-1:0] == AW'(DEPTH - 1)) begin
                  ptr_q[AW-1:0] <= '0;
                  ptr_q[AW]     <= ~ptr_q[AW];
               end else begin
                  ptr_q[AW-1:0] <= ptr_q[AW-1:0] + 1'b1;
               end
            end
         end
      end
   endgenerate

   assign ptr = ptr_q;
endmodule

// File: rtl/fifo9_mem.sv
module fifo9_mem #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/fifo9_thresh.sv
module fifo9_thresh
   import fifo9_pflag_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int INIT  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [WIDTH-1:0] din,
   input  logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] thr
);
   logic [WIDTH-1:0] thr_q = WIDTH'(INIT);
   tload_e           sel;

   assign sel = pick_tload(rst_n, wr_n, rd_n);

   always_ff @(posedge clk) begin
      unique case (sel)
         TL_FROM_IN:  thr_q <= din;
         TL_FROM_OUT: thr_q <= dout;
         default:     thr_q <= thr_q;
      endcase
   end

   assign thr = thr_q;
endmodule

// File: rtl/fifo9_flags.sv
module fifo9_flags
   import fifo9_pflag_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             rst_n,
   input  logic             armed,
   input  logic [AW:0]      wptr,
   input  logic [AW:0]      rptr,
   input  logic [WIDTH-1:0] thr,
   output logic [AW:0]      cnt,
   output logic             is_empty,
   output logic             is_full,
   output flags_t           flags
);
   localparam int CW = AW + 1;
   localparam int MW = (WIDTH > CW) ? WIDTH : CW;

   logic [AW-1:0] widx, ridx;
   logic          same_lap;
   logic          at_thr;

   assign widx     = wptr[AW-1:0];
   assign ridx     = rptr[AW-1:0];
   assign same_lap = (wptr[AW] == rptr[AW]);

   always_comb begin
      if (same_lap) cnt = CW'(widx) - CW'(ridx);
      else          cnt = CW'(DEPTH) + CW'(widx) - CW'(ridx);
   end

   assign is_empty = (cnt == '0);
   assign is_full  = (cnt == CW'(DEPTH));
   assign at_thr   = (MW'(cnt) >= MW'(thr));

   always_comb begin
      if (!rst_n || !armed) begin
         flags.empty_n = 1'b0;
         flags.full_n  = 1'b1;
         flags.half_n  = 1'b1;
      end else begin
         flags.empty_n = ~is_empty;
         flags.full_n  = ~is_full;
         flags.half_n  = ~at_thr;
      end
   end
endmodule

// File: rtl/fifo9_pflag.sv
module fifo9_pflag
   import fifo9_pflag_pkg::*;
#(
   parameter int WIDTH       = 9,
   parameter int DEPTH       = 16,
   parameter int THRESH_INIT = DEPTH / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fifo9_pflag: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fifo9_pflag: WIDTH must be positive");
      end
      if (THRESH_INIT >= (1 << WIDTH)) begin : g_bad_thr
         $error("fifo9_pflag: THRESH_INIT does not fit in WIDTH bits");
      end
   endgenerate

   logic             armed_q = 1'b0;
   logic [AW:0]      wptr, rptr;
   logic [CW-1:0]    cnt;
   logic             is_empty, is_full;
   logic             wr_ok, rd_ok;
   logic [WIDTH-1:0] rdata;
   logic [WIDTH-1:0] dout_q;
   logic [WIDTH-1:0] thr_q;
   flags_t           flg;

   // first reset arms the buffer
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b1;
   end

   assign wr_ok = rst_n && armed_q && !wr_n && !is_full;
   assign rd_ok = rst_n && armed_q && !rd_n && !is_empty;

   fifo9_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
      .clk (clk),
      .clr (!rst_n),
      .adv (wr_ok),
      .ptr (wptr)
   );

   fifo9_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
      .clk (clk),
      .clr (!rst_n),
      .adv (rd_ok),
      .ptr (rptr)
   );

   fifo9_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (wr_ok),
      .waddr (wptr[AW-1:0]),
      .wdata (din),
      .raddr (rptr[AW-1:0]),
      .rdata (rdata)
   );

   always_ff @(posedge clk) begin
      if (rd_ok) dout_q <= rdata;
   end

   fifo9_thresh #(.WIDTH(WIDTH), .INIT(THRESH_INIT)) u_thr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_n  (wr_n),
      .rd_n  (rd_n),
      .din   (din),
      .dout  (dout_q),
      .thr   (thr_q)
   );

   fifo9_flags #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_flags (
      .rst_n    (rst_n),
      .armed    (armed_q),
      .wptr     (wptr),
      .rptr     (rptr),
      .thr      (thr_q),
      .cnt      (cnt),
      .is_empty (is_empty),
      .is_full  (is_full),
      .flags    (flg)
   );

   assign dout    = dout_q;
   assign empty_n = flg.empty_n;
   assign full_n  = flg.full_n;
   assign half_n  = flg.half_n;
endmodule

// File: rtl/fifo9_pflag_chk.sv
module fifo9_pflag_chk #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_n,
   input logic             rd_n,
   input logic [WIDTH-1:0] dout,
   input logic             empty_n,
   input logic             full_n,
   input logic             half_n,
   input logic [CW-1:0]    cnt,
   input logic [WIDTH-1:0] thr,
   input logic             armed
);
   localparam int MW = (WIDTH > CW) ? WIDTH : CW;

   // R6
   rst_flags_chk: assert property (@(posedge clk) disable iff (!armed)
      !rst_n |-> (!empty_n && full_n && half_n));

   // R7
   half_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (!half_n == (MW'(cnt) >= MW'(thr))));

   // R8
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |=> $stable(dout));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && rd_n) |=> (!full_n && cnt == CW'(DEPTH)));

   // R10
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !empty_n && wr_n) |=> (!empty_n && $stable(dout)));

   // R11
   rw_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_n && full_n && !wr_n && !rd_n) |=> $stable(cnt));
endmodule

bind fifo9_pflag fifo9_pflag_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_n    (wr_n),
   .rd_n    (rd_n),
   .dout    (dout),
   .empty_n (empty_n),
   .full_n  (full_n),
   .half_n  (half_n),
   .cnt     (cnt),
   .thr     (thr_q),
   .armed   (armed_q)
);

// File: tb/fifo9_pflag_bench.sv
`timescale 1ns/1ps
module fifo9_pflag_bench;
   localparam int NV = 16;
   // {wr_n, rd_n, din[8:0], chk_dout, dout[8:0], empty_n, full_n, half_n}
   // state expected one rising edge after the vector; threshold is 4
   localparam logic [23:0] VEC [NV] = '{
      {1'b0, 1'b1, 9'h010, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b1, 9'h011, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b1, 9'h012, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b1, 9'h013, 1'b0, 9'h000, 1'b1, 1'b1, 1'b0},
      {1'b1, 1'b0, 9'h000, 1'b1, 9'h010, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b1, 9'h000, 1'b1, 9'h010, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b0, 9'h014, 1'b1, 9'h011, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b1, 9'h015, 1'b1, 9'h011, 1'b1, 1'b1, 1'b0},
      {1'b1, 1'b0, 9'h000, 1'b1, 9'h012, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b0, 9'h000, 1'b1, 9'h013, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b0, 9'h000, 1'b1, 9'h014, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b0, 9'h000, 1'b1, 9'h015, 1'b0, 1'b1, 1'b1},
      {1'b1, 1'b0, 9'h000, 1'b1, 9'h015, 1'b0, 1'b1, 1'b1},
      {1'b0, 1'b0, 9'h1AA, 1'b1, 9'h015, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b0, 9'h000, 1'b1, 9'h1AA, 1'b0, 1'b1, 1'b1},
      {1'b1, 1'b1, 9'h000, 1'b1, 9'h1AA, 1'b0, 1'b1, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       rd_n = 1'b1;
   logic [8:0] din = '0;
   logic [8:0] dout;
   logic       empty_n, full_n, half_n;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   fifo9_pflag u_fifo9_pflag (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
      .dout(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_flags(input string req, input logic e, input logic f, input logic h);
      check({empty_n, full_n, half_n} === {e, f, h}, req,
            int'({empty_n, full_n, half_n}), int'({e, f, h}));
   endtask

   task automatic chk_dout(input string req, input logic [8:0] exp);
      check(dout === exp, req, int'(dout), int'(exp));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cyc(input logic w, input logic r, input logic [8:0] d);
      wr_n = w; rd_n = r; din = d;
      step();
      wr_n = 1'b1; rd_n = 1'b1;
   endtask

   // one reset edge with the given strobes; checks the reset-phase flags (R6)
   task automatic do_reset(input logic w, input logic r, input logic [8:0] d);
      rst_n = 1'b0; wr_n = w; rd_n = r; din = d;
      step();
      chk_flags("R6 flags during reset", 1'b0, 1'b1, 1'b1);
      rst_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1600000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      finish_run();
   end

   initial begin
      @(negedge clk);
      // R2: no reset yet, strobes refused
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 1'b1, 9'(9'h0A0 + i));
         chk_flags("R2 pre-reset write ignored", 1'b0, 1'b1, 1'b1);
      end
      cyc(1'b1, 1'b0, 9'h000);
      chk_flags("R2 pre-reset read ignored", 1'b0, 1'b1, 1'b1);

      // R3: threshold 4 loaded from din
      do_reset(1'b0, 1'b1, 9'd4);
      cyc(1'b1, 1'b1, 9'h000);
      chk_flags("R1 empty after reset", 1'b0, 1'b1, 1'b1);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         v = VEC[i];
         cyc(v[23], v[22], v[21:13]);
         chk_flags($sformatf("R3 R7 R8 R10 R11 vector %0d flags", i), v[2], v[1], v[0]);
         if (v[12]) chk_dout($sformatf("R8 R10 R11 vector %0d dout", i), v[11:3]);
      end

      // R9: fill to full, overflow refused
      for (int k = 0; k < 16; k++) begin
         cyc(1'b0, 1'b1, 9'(9'h020 + k));
         check(full_n === (k != 15), "R9 full flag during fill", int'(full_n), int'(k != 15));
      end
      cyc(1'b0, 1'b1, 9'h0FF);
      chk_flags("R9 write while full", 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 9'h0EE);
      chk_dout("R9 read while full accepted", 9'h020);
      chk_flags("R9 write dropped on read while full", 1'b1, 1'b1, 1'b0);
      for (int k = 1; k < 16; k++) begin
         cyc(1'b1, 1'b0, 9'h000);
         chk_dout("R9 R8 drain order", 9'(9'h020 + k));
      end
      chk_flags("R9 drained empty", 1'b0, 1'b1, 1'b1);

      // R4: threshold taken from dout
      cyc(1'b0, 1'b1, 9'h002);
      cyc(1'b1, 1'b0, 9'h000);
      chk_dout("R8 setup dout", 9'h002);
      do_reset(1'b1, 1'b0, 9'h1F0);
      chk_dout("R4 dout unchanged in reset", 9'h002);
      cyc(1'b0, 1'b1, 9'h031);
      chk_flags("R4 count 1 below threshold 2", 1'b1, 1'b1, 1'b1);
      cyc(1'b0, 1'b1, 9'h032);
      chk_flags("R4 count 2 at threshold 2", 1'b1, 1'b1, 1'b0);

      // R5: plain reset keeps threshold; R1 pointers restart
      do_reset(1'b1, 1'b1, 9'h1FF);
      chk_flags("R1 stored data cleared by reset", 1'b0, 1'b1, 1'b1);
      cyc(1'b0, 1'b1, 9'h055);
      chk_flags("R5 count 1 below kept threshold", 1'b1, 1'b1, 1'b1);
      cyc(1'b0, 1'b1, 9'h066);
      chk_flags("R5 count 2 at kept threshold", 1'b1, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 9'h000);
      chk_dout("R1 first word after reset", 9'h055);

      // R7 boundary: threshold 0
      do_reset(1'b0, 1'b0, 9'h000);
      cyc(1'b1, 1'b1, 9'h000);
      chk_flags("R7 threshold 0 with empty buffer", 1'b0, 1'b1, 1'b0);

      finish_run();
   end
endmodule